// File: doc/BRIEF.md
# Lock-Bit Clear Command Controller

This block is the command state machine of a flash-style memory controller for one job: wiping every per-block write-protect bit in a single timed operation. Bus write cycles carry command bytes on `wr_data`. The block holds the per-block lock bits, a master lock bit and an 8-bit status byte. Protection is judged from three digital flags: program supply valid, reset pin at high voltage, and reset pin asserted. The first two are sampled on the confirm write. The third, together with the supply flag, is watched throughout the timed operation.

A clear takes two bus writes: a setup byte and then a confirm byte. If every gate passes, the bus-side status goes not-ready for a programmed number of cycles. After that, all lock bits drop to zero on the same edge. If a gate fails, sticky error bits are set and the lock bits keep their values. If the operation is interrupted, the lock contents are flagged as undefined until a later clear completes. After any command the block reports status on reads until a read-array byte is written.

The lock bits and the master bit are loaded from `boot_locks` and `boot_master` while reset is held. The master bit never changes afterwards.

States:
- `ST_ARRAY`: read-array mode.
- `ST_STATUS`: read-status mode.
- `ST_SETUP`: setup seen, waiting for the second write.
- `ST_BUSY`: timed clear in progress.

Transitions:
- `ST_ARRAY`/`ST_STATUS` go to `ST_SETUP` on a setup write.
- Read-status and read-array writes move between `ST_ARRAY` and `ST_STATUS`.
- `ST_SETUP` goes to `ST_BUSY` on an accepted confirm, and to `ST_STATUS` on any rejected second write.
- `ST_BUSY` goes to `ST_STATUS` on completion or on abort.

Top module: `lockclr_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `status` is 0x80, `status_mode` is 0, `lock_undef` is 0, and `lock_bits`/`master_lock` equal the values on `boot_locks`/`boot_master` during reset.
- R2: Command byte values are:
  - 0x60: clear setup.
  - 0xD0: confirm.
  - 0x50: clear status.
  - 0x70: read status.
  - 0xFF: read array.

  In either read mode, any other byte is ignored.
- R3: `status_mode` goes to 1 after a setup or read-status write and stays at 1 until a read-array write is accepted outside the busy period.
- R4: `status` bit layout:
  - bit 7: ready.
  - bit 5: clear error.
  - bit 4: sequence error.
  - bit 3: supply error.
  - bit 1: master-lock error.
  - bits 6, 2, 0: always 0.

  After an accepted confirm, bit 7 reads 0 for exactly BUSY_CYCLES cycles. Then every `lock_bits` bit becomes 0 on the same edge and `status` returns to 0x80.
- R5: A second write other than 0xD0 sets bits 4 and 5 and leaves the lock bits unchanged. This check wins over the supply and master checks.
- R6: A confirm with `vpp_ok` low sets bits 3 and 5 and leaves the lock bits unchanged. This check wins over the master check.
- R7: A confirm with `master_lock` at 1 and `rp_hv` at 0 sets bits 1 and 5 and leaves the lock bits unchanged.
- R8: With `master_lock` at 1 and `rp_hv` at 1, the confirm starts the clear as an override.
- R9: `master_lock` never changes after reset, including after an override clear.
- R10: Error bits stay set until a 0x50 write. That write clears bits 5, 4, 3 and 1 and does not change `status_mode`.
- R11: If `vpp_ok` goes low or `rst_pin_act` goes high during the busy period, the operation ends on the next edge. Bit 7 returns to 1, bit 5 is set, `lock_bits` keep their values and `lock_undef` becomes 1. `lock_undef` falls only when a later clear completes.
- R12: Bus writes during the busy period are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one byte per cycle |
| wr_data | input | 8 | Command byte |
| vpp_ok | input | 1 | Program supply within valid range |
| rp_hv | input | 1 | Reset pin held at high voltage (override level) |
| rst_pin_act | input | 1 | Reset pin asserted (aborts a running clear) |
| boot_locks | input | NBLK | Lock-bit values loaded during reset |
| boot_master | input | 1 | Master lock value loaded during reset |
| status | output | 8 | Status byte |
| status_mode | output | 1 | 1 when reads return status |
| lock_bits | output | NBLK | Per-block lock bits |
| master_lock | output | 1 | Master lock bit |
| lock_undef | output | 1 | Lock contents undefined after an abort |

## Verification
The clear is exercised from a table of gate combinations. Master bit, high-voltage flag, supply flag and second byte are varied so that each error pair is told apart from the others. Cases with two failing gates show which check takes precedence. The override case is set against the locked case that differs only in `rp_hv`.

Directed sequences cover four further points:
- The exact busy length, counted in cycles.
- Writes landing inside the busy period.
- Aborts caused by the supply flag and, separately, by the reset-pin flag, each followed by a recovering clear.
- Mode switching with stray bytes, and the sticky errors across mode changes.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [1:0] {
        ST_ARRAY  = 2'd0,
        ST_STATUS = 2'd1,
        ST_SETUP  = 2'd2,
        ST_BUSY   = 2'd3
    } lbc_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLRSR   = 8'h50;
    localparam logic [7:0] CMD_RDSR    = 8'h70;
    localparam logic [7:0] CMD_RDARR   = 8'hFF;

    typedef struct packed {
        logic start;
        logic done;
        logic abort;
        logic bad_seq;
        logic bad_vpp;
        logic bad_master;
        logic clr_sr;
    } lbc_evt_t;

endpackage

// File: rtl/lbc_cmd_fsm.sv
module lbc_cmd_fsm
    import lbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             vpp_ok,
    input  logic             rp_hv,
    input  logic             rst_pin_act,
    input  logic             master_lock,
    input  logic             timer_zero,
    output lbc_state_e       state_o,
    output lbc_evt_t         evt_o
);
    lbc_state_e state_q, state_d;
    lbc_evt_t   evt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARRAY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        evt     = '0;
        unique case (state_q)
            ST_ARRAY, ST_STATUS: begin
                if (wr_en) begin
                    if (wr_data == CMD_SETUP)      state_d = ST_SETUP;
                    else if (wr_data == CMD_RDSR)  state_d = ST_STATUS;
                    else if (wr_data == CMD_RDARR) state_d = ST_ARRAY;
                    else if (wr_data == CMD_CLRSR) evt.clr_sr = 1'b1;
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    state_d = ST_STATUS;
                    if (wr_data != CMD_CONFIRM)      evt.bad_seq = 1'b1;
                    else if (!vpp_ok)                evt.bad_vpp = 1'b1;
                    else if (master_lock && !rp_hv)  evt.bad_master = 1'b1;
                    else begin
                        evt.start = 1'b1;
                        state_d   = ST_BUSY;
                    end
                end
            end
            ST_BUSY: begin
                if (!vpp_ok || rst_pin_act) begin
                    evt.abort = 1'b1;
                    state_d   = ST_STATUS;
                end else if (timer_zero) begin
                    evt.done = 1'b1;
                    state_d  = ST_STATUS;
                end
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    assign state_o = state_q;
    assign evt_o   = evt;

    // R12
    busy_ignores_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && wr_en && vpp_ok && !rst_pin_act && !timer_zero)
        |=> (state_q == ST_BUSY));

    // R11
    abort_exits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && rst_pin_act) |=> (state_q == ST_STATUS));

endmodule

// File: rtl/lbc_busy_timer.sv
module lbc_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= LAST;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/lbc_status_reg.sv
module lbc_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       bad_seq,
    input  logic       bad_vpp,
    input  logic       bad_master,
    input  logic       abort,
    input  logic       clr_sr,
    output logic [7:0] status
);
    logic clr_err_q, seq_err_q, vpp_err_q, mst_err_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_sr) begin
            clr_err_q <= 1'b0;
            seq_err_q <= 1'b0;
            vpp_err_q <= 1'b0;
            mst_err_q <= 1'b0;
        end else begin
            if (bad_seq || bad_vpp || bad_master || abort) clr_err_q <= 1'b1;
            if (bad_seq)    seq_err_q <= 1'b1;
            if (bad_vpp)    vpp_err_q <= 1'b1;
            if (bad_master) mst_err_q <= 1'b1;
        end
    end

    assign status = {ready, 1'b0, clr_err_q, seq_err_q, vpp_err_q, 1'b0, mst_err_q, 1'b0};

    // R5
    seq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err_q) |-> clr_err_q);

    // R6
    vpp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_err_q) |-> clr_err_q);

    // R7
    mst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_err_q) |-> clr_err_q);

endmodule

// File: rtl/lbc_lock_store.sv
module lbc_lock_store #(
    parameter int NBLK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBLK-1:0] boot_locks,
    input  logic            boot_master,
    input  logic            done,
    input  logic            abort,
    output logic [NBLK-1:0] lock_q,
    output logic            master_q,
    output logic            undef_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= boot_locks;
            master_q <= boot_master;
            undef_q  <= 1'b0;
        end else if (done) begin
            lock_q  <= '0;
            undef_q <= 1'b0;
        end else if (abort) begin
            undef_q <= 1'b1;
        end
    end

    // R4
    lock_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(lock_q)) |-> $past(done));

    // R9
    master_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(master_q));

endmodule

// File: rtl/lockclr_ctrl.sv
module lockclr_ctrl
    import lbc_pkg::*;
#(
    parameter int NBLK        = 8,
    parameter int BUSY_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic            vpp_ok,
    input  logic            rp_hv,
    input  logic            rst_pin_act,
    input  logic [NBLK-1:0] boot_locks,
    input  logic            boot_master,
    output logic [7:0]      status,
    output logic            status_mode,
    output logic [NBLK-1:0] lock_bits,
    output logic            master_lock,
    output logic            lock_undef
);
    lbc_state_e state;
    lbc_evt_t   evt;
    logic       timer_zero;

    lbc_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .vpp_ok(vpp_ok), .rp_hv(rp_hv), .rst_pin_act(rst_pin_act),
        .master_lock(master_lock), .timer_zero(timer_zero),
        .state_o(state), .evt_o(evt)
    );

    lbc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(evt.start),
        .run(state == ST_BUSY), .zero(timer_zero)
    );

    lbc_status_reg u_sr (
        .clk(clk), .rst_n(rst_n), .ready(state != ST_BUSY),
        .bad_seq(evt.bad_seq), .bad_vpp(evt.bad_vpp),
        .bad_master(evt.bad_master), .abort(evt.abort),
        .clr_sr(evt.clr_sr), .status(status)
    );

    lbc_lock_store #(.NBLK(NBLK)) u_store (
        .clk(clk), .rst_n(rst_n), .boot_locks(boot_locks),
        .boot_master(boot_master), .done(evt.done), .abort(evt.abort),
        .lock_q(lock_bits), .master_q(master_lock), .undef_q(lock_undef)
    );

    assign status_mode = (state != ST_ARRAY);

endmodule

// File: tb/lockclr_ctrl_bench.sv
module lockclr_ctrl_bench;
    localparam int NBLK = 8;
    localparam int BUSY = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_data = 8'h00;
    logic            vpp_ok = 1'b1;
    logic            rp_hv = 1'b0;
    logic            rst_pin_act = 1'b0;
    logic [NBLK-1:0] boot_locks = 8'hA5;
    logic            boot_master = 1'b0;
    logic [7:0]      status;
    logic            status_mode;
    logic [NBLK-1:0] lock_bits;
    logic            master_lock;
    logic            lock_undef;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lockclr_ctrl #(.NBLK(NBLK), .BUSY_CYCLES(BUSY)) u_lockclr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .vpp_ok(vpp_ok), .rp_hv(rp_hv), .rst_pin_act(rst_pin_act),
        .boot_locks(boot_locks), .boot_master(boot_master),
        .status(status), .status_mode(status_mode), .lock_bits(lock_bits),
        .master_lock(master_lock), .lock_undef(lock_undef)
    );

    // {master, rp_hv, vpp_ok, cleared, second byte, expected status}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 1'b1, 8'hD0, 8'h80},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 8'hB0},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hD0, 8'hA8},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'hD0, 8'hA2},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'hD0, 8'h80},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hD0, 8'hA8},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h60, 8'hB0},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'hD0, 8'hA8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [NBLK-1:0] locks, input logic mst);
        @(negedge clk);
        rst_n = 1'b0;
        boot_locks = locks;
        boot_master = mst;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        // R1 reset state
        do_reset(8'h3C, 1'b1);
        check("R1 status", status, 8'h80);
        check("R1 mode", status_mode, 1'b0);
        check("R1 locks", lock_bits, 8'h3C);
        check("R1 master", master_lock, 1'b1);
        check("R1 undef", lock_undef, 1'b0);

        // Table of gate combinations (R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 8; i++) begin
            do_reset(8'hA5, VEC[i][19]);
            rp_hv = VEC[i][18];
            vpp_ok = VEC[i][17];
            wr(8'h60);
            wr(VEC[i][15:8]);
            repeat (BUSY + 3) @(negedge clk);
            check("R5/R6/R7/R8 status", status, VEC[i][7:0]);
            check("R4/R8 locks", lock_bits, VEC[i][16] ? 8'h00 : 8'hA5);
            check("R3 mode", status_mode, 1'b1);
            check("R9 master", master_lock, VEC[i][19]);
        end
        rp_hv = 1'b0;
        vpp_ok = 1'b1;

        // R4 exact busy length
        do_reset(8'hFF, 1'b0);
        wr(8'h60);
        wr(8'hD0);
        begin
            int cnt = 0;
            while (status[7] == 1'b0 && cnt < 100) begin
                cnt++;
                @(negedge clk);
            end
            check("R4 busy cycles", cnt, BUSY);
        end
        check("R4 locks cleared", lock_bits, 8'h00);

        // R12 writes during busy ignored
        do_reset(8'h0F, 1'b0);
        wr(8'h60);
        wr(8'hD0);
        wr(8'hFF);
        wr(8'h60);
        repeat (BUSY + 2) @(negedge clk);
        check("R12 status", status, 8'h80);
        check("R12 mode", status_mode, 1'b1);
        check("R12 locks", lock_bits, 8'h00);

        // R11 abort by supply drop, then recovery
        do_reset(8'hA5, 1'b0);
        wr(8'h60);
        wr(8'hD0);
        @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        check("R11 status", status, 8'hA0);
        check("R11 undef", lock_undef, 1'b1);
        check("R11 locks kept", lock_bits, 8'hA5);
        vpp_ok = 1'b1;
        wr(8'h50);
        check("R10 cleared", status, 8'h80);
        check("R10 mode kept", status_mode, 1'b1);
        check("R11 undef held", lock_undef, 1'b1);
        wr(8'h60);
        wr(8'hD0);
        repeat (BUSY + 2) @(negedge clk);
        check("R11 undef cleared", lock_undef, 1'b0);
        check("R11 locks zero", lock_bits, 8'h00);

        // R11 abort by reset pin
        do_reset(8'h5A, 1'b0);
        wr(8'h60);
        wr(8'hD0);
        rst_pin_act = 1'b1;
        @(negedge clk);
        rst_pin_act = 1'b0;
        check("R11 pin status", status, 8'hA0);
        check("R11 pin undef", lock_undef, 1'b1);
        repeat (BUSY + 2) @(negedge clk);
        check("R11 pin locks", lock_bits, 8'h5A);

        // R2 R3 mode switching, R5 and R10 sticky errors
        do_reset(8'h11, 1'b0);
        wr(8'h12);
        check("R2 stray byte", status_mode, 1'b0);
        check("R2 stray status", status, 8'h80);
        wr(8'h70);
        check("R3 read status", status_mode, 1'b1);
        wr(8'hFF);
        check("R3 read array", status_mode, 1'b0);
        wr(8'h60);
        check("R3 setup mode", status_mode, 1'b1);
        wr(8'hFF);
        check("R5 bad second", status, 8'hB0);
        check("R3 stays status", status_mode, 1'b1);
        wr(8'h70);
        check("R10 sticky rdsr", status, 8'hB0);
        wr(8'hFF);
        check("R10 sticky array", status, 8'hB0);
        check("R3 back to array", status_mode, 1'b0);
        wr(8'h50);
        check("R10 clear", status, 8'h80);
        check("R10 mode unchanged", status_mode, 1'b0);
        check("R5 locks kept", lock_bits, 8'h11);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule